// File: doc/BRIEF.md
# Interval Timer Host Register Port

This block sits between a byte-wide host bus and the counter cores of a three-channel interval timer. It presents four byte addresses: one data address per channel (addresses 0, 1 and 2) and a control address (3). Writes to the control address program a channel's operating mode, byte access order and decimal flag. They can also freeze a channel's count, or freeze count and status for several channels at once. Writes to a data address assemble a 16-bit start value and hand it to the selected counter with a one-cycle load strobe.

Reads from a data address return a byte. The source is chosen in a fixed order. A pending status snapshot comes first. A frozen count comes next, one byte per read in the frozen access order. Otherwise the byte comes from the channel's live count, which arrives on an input. Read and write byte order are tracked separately per channel. Reprogramming a channel restarts both. The counting logic is outside this block: it receives the load strobe, load value and mode, and returns its live count and output level.

Top module: `tmr_host_port`

## Requirements
- R1: After synchronous reset every channel reports operating mode 3 and decimal flag 0, has access order 0 and holds no frozen count or status. Access order 0 behaves as low-byte-only for data reads, data writes and count freezing.
- R2: A control byte whose bits 7:6 name channel 0, 1 or 2 and whose bits 5:4 are nonzero stores bits 5:4 as the access order, bits 3:1 as the operating mode and bit 0 as the decimal flag. Mode codes 6 and 7 are stored and reported as 2 and 3.
- R3: In low-byte-only order a data write loads {8'h00, byte}. In high-byte-only order it loads {byte, 8'h00}. The load strobe is high for exactly the cycle after the write.
- R4: In two-byte order (3), the first data write only stores the low byte and raises no strobe. The second write loads {second, first}.
- R5: A control byte with nonzero access order restarts both the write byte sequence and the read byte sequence of that channel at the low byte.
- R6: Without a frozen value, a data read returns the live count's low byte (order 1), its high byte (order 2), or low and high bytes alternately, starting low (order 3).
- R7: A control byte with bits 5:4 equal to 0 freezes the live count of the channel in bits 7:6. Following reads return the frozen bytes in the channel's access order, and after the last frozen byte reads return live bytes again. Frozen reads do not advance the live read sequence.
- R8: A count freeze request for a channel whose frozen count is not yet fully read is ignored.
- R9: A control byte with bits 7:6 equal to 3 is a read-back command. Bit c+1 selects channel c. Bit 5 low freezes the count of every selected channel, and bit 4 low freezes its status. Channels not selected are untouched.
- R10: The status byte is {output level, 0, access order[1:0], mode[2:0], decimal flag}. A pending status is returned before any frozen count, then cleared. A status freeze while one is pending is ignored.
- R11: A data read returns its byte on rd_data with rd_valid high in the cycle after the request. A read of the control address returns no data: rd_valid stays low.
- R12: A data write strobes only the addressed channel's load output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Host write request |
| bus_rd | input | 1 | Host read request (ignored when bus_wr is high) |
| bus_addr | input | 2 | 0..2 channel data, 3 control |
| bus_wdata | input | 8 | Host write byte |
| rd_data | output | 8 | Read byte, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after a data read |
| live_cnt | input | 48 | Live count per channel, channel c at bits 16c+15:16c |
| out_lvl | input | 3 | Counter output level per channel |
| load_pulse | output | 3 | Per-channel load strobe |
| load_val | output | 48 | Per-channel start value, channel c at bits 16c+15:16c |
| chan_mode | output | 9 | Per-channel operating mode, channel c at bits 3c+2:3c |
| chan_bcd | output | 3 | Per-channel decimal flag |

## Verification
Every cycle, the assertions check several rules. A load strobe follows only a data write, and at most one channel strobes. A frozen count holds until it is read. A pending status clears on the read that returns it. A control-address read never produces valid data. A stored mode is never 6 or 7. The bench scenarios are the only way to show the byte orders: two-byte assembly and alternation, the restart of both sequences on reprogramming, and the priority of status over frozen count over live count. They also show the multi-channel read-back and that a second freeze is ignored when the frozen value differs from the new live value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int BYTE_W   = 8;
   localparam int CNT_W    = 2 * BYTE_W;
   localparam int MODE_W   = 3;
   localparam int ADDR_W   = 2;
   localparam logic [ADDR_W-1:0] CTL_ADDR = 2'd3;

   typedef enum logic [1:0] {
      ACC_LATCH = 2'd0,
      ACC_LO    = 2'd1,
      ACC_HI    = 2'd2,
      ACC_WORD  = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      LAT_NONE = 2'd0,
      LAT_LO   = 2'd1,
      LAT_HI   = 2'd2,
      LAT_WORD = 2'd3
   } lat_e;
endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
   import tmr_pkg::*;
#(
   parameter int NUM_CH = 3
)(
   input  logic                ctl_we,
   input  logic [BYTE_W-1:0]   ctl_byte,
   output logic [NUM_CH-1:0]   cfg_we,
   output logic [NUM_CH-1:0]   cnt_latch,
   output logic [NUM_CH-1:0]   stat_latch,
   output acc_e                acc,
   output logic [MODE_W-1:0]   mode,
   output logic                bcd
);
   logic [1:0]        sel;
   logic              is_rb;
   logic [MODE_W-1:0] raw_mode;

   assign sel      = ctl_byte[7:6];
   assign is_rb    = (sel == 2'b11);
   assign acc      = acc_e'(ctl_byte[5:4]);
   assign raw_mode = ctl_byte[3:1];
   assign bcd      = ctl_byte[0];
   // codes 6 and 7 fold onto 2 and 3
   assign mode     = (raw_mode[2] & raw_mode[1]) ? {1'b0, raw_mode[1:0]} : raw_mode;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      logic hit;
      logic rb_sel;
      assign hit           = ctl_we && !is_rb && (sel == 2'(c));
      assign rb_sel        = ctl_we && is_rb && ctl_byte[c+1];
      assign cfg_we[c]     = hit && (acc != ACC_LATCH);
      assign cnt_latch[c]  = (hit && (acc == ACC_LATCH)) || (rb_sel && !ctl_byte[5]);
      assign stat_latch[c] = rb_sel && !ctl_byte[4];
   end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
   import tmr_pkg::*;
#(
   parameter logic [MODE_W-1:0] RESET_MODE = 3'd3
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  acc_e               new_acc,
   input  logic [MODE_W-1:0]  new_mode,
   input  logic               new_bcd,
   input  logic               cnt_latch,
   input  logic               stat_latch,
   input  logic               data_we,
   input  logic               data_rd,
   input  logic [BYTE_W-1:0]  wdata,
   input  logic [CNT_W-1:0]   live_cnt,
   input  logic               out_lvl,
   output logic [BYTE_W-1:0]  rd_byte,
   output logic               load_pulse,
   output logic [CNT_W-1:0]   load_val,
   output logic [MODE_W-1:0]  mode_o,
   output logic               bcd_o
);
   acc_e              acc_q;
   acc_e              acc_eff;
   logic [MODE_W-1:0] mode_q;
   logic              bcd_q;
   logic              wr_hi_q;
   logic              rd_hi_q;
   logic [BYTE_W-1:0] wr_lo_q;
   lat_e              lat_q;
   logic [CNT_W-1:0]  lat_val_q;
   logic              stat_pend_q;
   logic [BYTE_W-1:0] stat_q;
   logic [BYTE_W-1:0] status_now;

   assign acc_eff    = (acc_q == ACC_LATCH) ? ACC_LO : acc_q;
   assign status_now = {out_lvl, 1'b0, acc_q, mode_q, bcd_q};
   assign mode_o     = mode_q;
   assign bcd_o      = bcd_q;

   always_comb begin
      if (stat_pend_q) begin
         rd_byte = stat_q;
      end else begin
         unique case (lat_q)
            LAT_LO, LAT_WORD: rd_byte = lat_val_q[BYTE_W-1:0];
            LAT_HI:           rd_byte = lat_val_q[CNT_W-1:BYTE_W];
            default: begin
               unique case (acc_eff)
                  ACC_HI:   rd_byte = live_cnt[CNT_W-1:BYTE_W];
                  ACC_WORD: rd_byte = rd_hi_q ? live_cnt[CNT_W-1:BYTE_W]
                                              : live_cnt[BYTE_W-1:0];
                  default:  rd_byte = live_cnt[BYTE_W-1:0];
               endcase
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q       <= ACC_LATCH;
         mode_q      <= RESET_MODE;
         bcd_q       <= 1'b0;
         wr_hi_q     <= 1'b0;
         rd_hi_q     <= 1'b0;
         wr_lo_q     <= '0;
         lat_q       <= LAT_NONE;
         lat_val_q   <= '0;
         stat_pend_q <= 1'b0;
         stat_q      <= '0;
         load_pulse  <= 1'b0;
         load_val    <= '0;
      end else begin
         load_pulse <= 1'b0;
         if (cfg_we) begin
            acc_q   <= new_acc;
            mode_q  <= new_mode;
            bcd_q   <= new_bcd;
            wr_hi_q <= 1'b0;
            rd_hi_q <= 1'b0;
         end
         if (cnt_latch && (lat_q == LAT_NONE)) begin
            lat_q     <= lat_e'(acc_eff);
            lat_val_q <= live_cnt;
         end
         if (stat_latch && !stat_pend_q) begin
            stat_pend_q <= 1'b1;
            stat_q      <= status_now;
         end
         if (data_we) begin
            unique case (acc_eff)
               ACC_HI: begin
                  load_pulse <= 1'b1;
                  load_val   <= {wdata, {BYTE_W{1'b0}}};
               end
               ACC_WORD: begin
                  if (wr_hi_q) begin
                     load_pulse <= 1'b1;
                     load_val   <= {wdata, wr_lo_q};
                     wr_hi_q    <= 1'b0;
                  end else begin
                     wr_lo_q <= wdata;
                     wr_hi_q <= 1'b1;
                  end
               end
               default: begin
                  load_pulse <= 1'b1;
                  load_val   <= {{BYTE_W{1'b0}}, wdata};
               end
            endcase
         end
         if (data_rd) begin
            if (stat_pend_q) begin
               stat_pend_q <= 1'b0;
            end else if (lat_q != LAT_NONE) begin
               lat_q <= (lat_q == LAT_WORD) ? LAT_HI : LAT_NONE;
            end else if (acc_eff == ACC_WORD) begin
               rd_hi_q <= ~rd_hi_q;
            end
         end
      end
   end

   // R3
   load_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_pulse |-> $past(data_we));

   // R8
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q != LAT_NONE && !data_rd) |=> $stable(lat_val_q));

   // R10
   stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_pend_q && data_rd) |=> !stat_pend_q);

   // R2
   mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode_o[2] && mode_o[1]));
endmodule

// File: rtl/tmr_host_port.sv
module tmr_host_port
   import tmr_pkg::*;
#(
   parameter int                NUM_CH     = 3,
   parameter logic [MODE_W-1:0] RESET_MODE = 3'd3
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_wr,
   input  logic                       bus_rd,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [BYTE_W-1:0]          bus_wdata,
   output logic [BYTE_W-1:0]          rd_data,
   output logic                       rd_valid,
   input  logic [NUM_CH*CNT_W-1:0]    live_cnt,
   input  logic [NUM_CH-1:0]          out_lvl,
   output logic [NUM_CH-1:0]          load_pulse,
   output logic [NUM_CH*CNT_W-1:0]    load_val,
   output logic [NUM_CH*MODE_W-1:0]   chan_mode,
   output logic [NUM_CH-1:0]          chan_bcd
);
   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_num_ch
      $error("tmr_host_port: NUM_CH must be 1..3");
   end
   if (RESET_MODE > 3'd5) begin : g_bad_reset_mode
      $error("tmr_host_port: RESET_MODE must be 0..5");
   end

   logic              rd_go;
   logic              ctl_we;
   logic              addr_is_chan;
   logic [NUM_CH-1:0] cfg_we;
   logic [NUM_CH-1:0] cnt_latch;
   logic [NUM_CH-1:0] stat_latch;
   acc_e              dec_acc;
   logic [MODE_W-1:0] dec_mode;
   logic              dec_bcd;
   logic [BYTE_W-1:0] ch_byte [NUM_CH];
   logic [BYTE_W-1:0] rd_mux;

   assign rd_go        = bus_rd && !bus_wr;
   assign ctl_we       = bus_wr && (bus_addr == CTL_ADDR);
   assign addr_is_chan = (int'(bus_addr) < NUM_CH);

   tmr_ctl_decode #(.NUM_CH(NUM_CH)) i_dec (
      .ctl_we    (ctl_we),
      .ctl_byte  (bus_wdata),
      .cfg_we    (cfg_we),
      .cnt_latch (cnt_latch),
      .stat_latch(stat_latch),
      .acc       (dec_acc),
      .mode      (dec_mode),
      .bcd       (dec_bcd)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic sel;
      assign sel = (int'(bus_addr) == c);
      tmr_chan_regs #(.RESET_MODE(RESET_MODE)) i_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_we    (cfg_we[c]),
         .new_acc   (dec_acc),
         .new_mode  (dec_mode),
         .new_bcd   (dec_bcd),
         .cnt_latch (cnt_latch[c]),
         .stat_latch(stat_latch[c]),
         .data_we   (bus_wr && sel),
         .data_rd   (rd_go && sel),
         .wdata     (bus_wdata),
         .live_cnt  (live_cnt[c*CNT_W +: CNT_W]),
         .out_lvl   (out_lvl[c]),
         .rd_byte   (ch_byte[c]),
         .load_pulse(load_pulse[c]),
         .load_val  (load_val[c*CNT_W +: CNT_W]),
         .mode_o    (chan_mode[c*MODE_W +: MODE_W]),
         .bcd_o     (chan_bcd[c])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (int'(bus_addr) == c) rd_mux = ch_byte[c];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_go && addr_is_chan;
         rd_data  <= (rd_go && addr_is_chan) ? rd_mux : '0;
      end
   end

   // R11
   ctl_read_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && bus_addr == CTL_ADDR) |=> !rd_valid);

   // R11
   read_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_go));

   // R12
   one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load_pulse));
endmodule

// File: tb/test_tmr_host_port.sv
module test_tmr_host_port;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [1:0]        bus_addr = '0;
   logic [7:0]        bus_wdata = '0;
   logic [7:0]        rd_data;
   logic              rd_valid;
   logic [NCH*16-1:0] live_cnt = '0;
   logic [NCH-1:0]    out_lvl = '0;
   logic [NCH-1:0]    load_pulse;
   logic [NCH*16-1:0] load_val;
   logic [NCH*3-1:0]  chan_mode;
   logic [NCH-1:0]    chan_bcd;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_host_port i_tmr_host_port (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
      .rd_valid(rd_valid), .live_cnt(live_cnt), .out_lvl(out_lvl),
      .load_pulse(load_pulse), .load_val(load_val), .chan_mode(chan_mode),
      .chan_bcd(chan_bcd)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected bytes as read data appears
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R11 unexpected read data actual=%0h expected=none", rd_data);
         end else begin
            chk({24'h0, rd_data}, {24'h0, exp_q[0]}, tag_q[0]);
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
         end
      end
   end

   task automatic cyc(input logic w, input logic r, input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic ctl(input logic [7:0] d);
      cyc(1'b1, 1'b0, 2'd3, d);
   endtask

   task automatic wr(input logic [1:0] ch, input logic [7:0] d);
      cyc(1'b1, 1'b0, ch, d);
   endtask

   task automatic rd(input logic [1:0] ch, input logic [7:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      cyc(1'b0, 1'b1, ch, 8'h00);
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      live_cnt = {16'hBEEF, 16'h4321, 16'h1234};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int c = 0; c < NCH; c++) begin
         chk({29'h0, chan_mode[3*c +: 3]}, 32'd3, "R1 reset mode");
         chk({31'h0, chan_bcd[c]}, 32'd0, "R1 reset bcd");
      end
      chk({31'h0, rd_valid}, 32'd0, "R1 reset rd_valid");
      rd(2'd0, 8'h34, "R1 access 0 reads low");
      rd(2'd0, 8'h34, "R1 access 0 stays low");

      // R2 / R4 two-byte write, mode 2
      ctl(8'h34);
      chk({29'h0, chan_mode[2:0]}, 32'd2, "R2 mode ch0");
      wr(2'd0, 8'hAA);
      chk({29'h0, load_pulse}, 32'd0, "R4 first byte no load");
      wr(2'd0, 8'h55);
      chk({29'h0, load_pulse}, 32'd1, "R4 load strobe");
      chk({16'h0, load_val[15:0]}, 32'h55AA, "R4 load value");
      // R6 alternate reads
      rd(2'd0, 8'h34, "R6 word low");
      rd(2'd0, 8'h12, "R6 word high");
      rd(2'd0, 8'h34, "R6 word low again");

      // R2 alias 6->2, bcd; R3 low-only; R12
      ctl(8'h5D);
      chk({29'h0, chan_mode[5:3]}, 32'd2, "R2 mode 6 alias");
      chk({31'h0, chan_bcd[1]}, 32'd1, "R2 bcd");
      wr(2'd1, 8'h77);
      chk({29'h0, load_pulse}, 32'd2, "R12 only ch1 strobes");
      chk({16'h0, load_val[31:16]}, 32'h0077, "R3 low-only load");

      // R2 alias 7->3, R3 high-only, R6 high-only read
      ctl(8'hAE);
      chk({29'h0, chan_mode[8:6]}, 32'd3, "R2 mode 7 alias");
      wr(2'd2, 8'h9C);
      chk({29'h0, load_pulse}, 32'd4, "R3 high-only strobe");
      chk({16'h0, load_val[47:32]}, 32'h9C00, "R3 high-only load");
      rd(2'd2, 8'hBE, "R6 high-only read");
      rd(2'd2, 8'hBE, "R6 high-only repeat");

      // R5 reprogramming restarts both sequences (ch0 read sequence sits on high)
      wr(2'd0, 8'h11);
      ctl(8'h30);
      wr(2'd0, 8'h22);
      chk({29'h0, load_pulse}, 32'd0, "R5 write sequence restarted");
      wr(2'd0, 8'h33);
      chk({16'h0, load_val[15:0]}, 32'h3322, "R5 load after restart");
      rd(2'd0, 8'h34, "R5 read sequence restarted");

      // R7 / R8 count freeze
      ctl(8'h00);
      live_cnt[15:0] = 16'h5678;
      ctl(8'h00);
      rd(2'd0, 8'h34, "R7 frozen low");
      rd(2'd0, 8'h12, "R8 second freeze ignored");
      rd(2'd0, 8'h56, "R7 back to live, sequence kept");

      // R10 status freeze ignored while pending
      out_lvl = 3'b000;
      ctl(8'hE4);
      out_lvl = 3'b010;
      ctl(8'hE4);
      rd(2'd1, 8'h15, "R10 status byte");
      rd(2'd1, 8'h21, "R10 status cleared then live");

      // R9 read-back on ch0 and ch2, count and status
      out_lvl = 3'b101;
      ctl(8'hCA);
      live_cnt[15:0]  = 16'h0F0F;
      live_cnt[47:32] = 16'h1111;
      rd(2'd0, 8'hB0, "R9 ch0 status first");
      rd(2'd0, 8'h78, "R9 ch0 frozen low");
      rd(2'd0, 8'h56, "R9 ch0 frozen high");
      rd(2'd0, 8'h0F, "R9 ch0 live after");
      rd(2'd2, 8'hA6, "R9 ch2 status first");
      rd(2'd2, 8'hBE, "R9 ch2 frozen high-only");
      rd(2'd2, 8'h11, "R9 ch2 live after");
      rd(2'd1, 8'h21, "R9 ch1 not selected");

      // R11 control address read
      cyc(1'b0, 1'b1, 2'd3, 8'h00);
      chk({31'h0, rd_valid}, 32'd0, "R11 control read no data");
      chk({29'h0, load_pulse}, 32'd0, "R11 control read no load");

      repeat (3) @(negedge clk);
      chk(exp_q.size(), 32'd0, "R11 all reads returned");
      summary();
      $finish;
   end
endmodule